// File: doc/BRIEF.md
# SDRAM Refresh and Clock-Enable Manager

This block keeps an SDRAM array refreshed and controls its clock-enable pin. A programmable interval timer produces refresh requests toward the command sequencer. The timer runs only while at least one memory channel is enabled. Requests that the sequencer has not yet taken are kept, up to a small backlog. A separate 5-bit counter loaded by software counts completed refreshes down to zero and then stops. It is used to pace the burst of refreshes needed at memory initialization.

With automatic power-down selected, the clock-enable output drops whenever no refresh is owed, no access or command is requested and no operation is in progress. A new demand raises clock-enable first. One cycle with clock-enable high is then counted before the refresh request or the access grant is passed on. The sequencer must assert `op_busy_i` from the cycle after it accepts a request until the operation is finished. A second option moves every clock-enable transition one cycle earlier.

Top module: `sdram_refresh_cke_mgr`

## Requirements
- R1: After reset `cke_o` is 1, `ref_req_o` and `op_gnt_o` are 0, `rcnt_o` is 0, the refresh interval is 0x30C (780) cycles, and both power options are off.
- R2: While any bit of `chan_en_i` is 1, a refresh becomes owed every max(P,1) cycles, where P is the programmed interval. A write to the interval, sampled at a clock edge, restarts the count from the new value, and the first request appears P edges after that write edge.
- R3: While `chan_en_i` is all zero, no new refresh becomes owed and the interval count is held at its reload value.
- R4: `ref_req_o` stays 1 until a handshake, which is a cycle with both `ref_req_o` and `ref_ack_i` at 1. Each handshake retires one owed refresh, and up to 3 owed refreshes are kept.
- R5: A write on `rcnt_we_i` loads `rcnt_o`. Each refresh handshake decrements a non-zero `rcnt_o` by one. At zero it holds until software writes it again.
- R6: With `pd_auto_i` at 0, `cke_o` stays 1, and both `ref_req_o` and `op_gnt_o` follow their demand in the same cycle.
- R7: With `pd_auto_i` at 1 and `cke_early_i` at 0, `cke_o` is 0 while no refresh is owed and `op_req_i` and `op_busy_i` are both 0. It goes to 1 one edge after a demand appears and returns to 0 one edge after all demand and busy are gone.
- R8: `ref_req_o` and `op_gnt_o` are 1 only when `cke_o` is 1 and was also 1 in the previous cycle. So after a wake-up they are forwarded one cycle after `cke_o` rises.
- R9: With `cke_early_i` at 1, every `cke_o` transition occurs in the cycle of its cause, one cycle earlier than under R7, and forwarding follows one cycle after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_we_i | input | 1 | Load refresh interval |
| period_i | input | 12 | Refresh interval in cycles |
| rcnt_we_i | input | 1 | Load init refresh counter |
| rcnt_i | input | 5 | Init refresh counter value |
| pd_auto_i | input | 1 | Automatic power-down enable |
| cke_early_i | input | 1 | One-cycle-early clock-enable timing |
| chan_en_i | input | NUM_CH | Channel enables; refresh runs while any is set |
| ref_req_o | output | 1 | Refresh request to sequencer |
| ref_ack_i | input | 1 | Sequencer accepts refresh |
| op_req_i | input | 1 | Access or command pending upstream |
| op_gnt_o | output | 1 | Access or command may be issued |
| op_busy_i | input | 1 | Sequencer operation in progress |
| cke_o | output | 1 | SDRAM clock enable |
| rcnt_o | output | 5 | Init refresh counter value |

## Verification
The bench measures request latency for several intervals, including 0 and 1, where the timer fires every cycle. A design that reloaded one cycle late would show intervals of P+1, and one that lost a refresh when a tick coincided with an acknowledge would drop requests. A backlog of two owed refreshes is drained one handshake at a time to catch a single-flag request that merges them. The init counter is pushed past zero, so a wrap to 31 would be caught. Clock-enable rise, grant and fall are checked at exact cycles in both timing modes, which exposes a grant issued while clock-enable is still low or an early mode that shifts only one of the two edges.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int PERIOD_W = 12;
  localparam int RCNT_W   = 5;
  localparam logic [PERIOD_W-1:0] PERIOD_RST = 12'h30C;
endpackage

// File: rtl/rcm_period_timer.sv
module rcm_period_timer #(
  parameter int PW = 12,
  parameter int PEND_W = 2,
  parameter logic [PW-1:0] RST_PERIOD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          period_we_i,
  input  logic [PW-1:0] period_i,
  input  logic          run_i,
  input  logic          take_i,
  output logic          owed_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PW-1:0]     period_q, cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              tick;

  assign tick   = run_i && !period_we_i && (cnt_q < PW'(2));
  assign owed_o = (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= RST_PERIOD;
      cnt_q    <= RST_PERIOD;
    end else if (period_we_i) begin
      period_q <= period_i;
      cnt_q    <= period_i;
    end else if (!run_i || tick) begin
      cnt_q <= period_q;
    end else begin
      cnt_q <= cnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (tick && !take_i) begin
      if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_W'(1);
    end else if (take_i && !tick) begin
      pend_q <= pend_q - PEND_W'(1);
    end
  end

  p_owed_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !take_i && (pend_q != PEND_MAX) |=> pend_q == $past(pend_q) + PEND_W'(1));
  p_take_retires_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !tick |=> pend_q == $past(pend_q) - PEND_W'(1));
  p_idle_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !take_i |=> pend_q == $past(pend_q));
endmodule

// File: rtl/rcm_init_counter.sv
module rcm_init_counter #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          done_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (done_i && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o = cnt_q;

  p_zero_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !load_i |=> cnt_q == '0);
  p_dec_per_refresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !load_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/rcm_cke_ctrl.sv
module rcm_cke_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_auto_i,
  input  logic early_i,
  input  logic demand_i,
  input  logic busy_i,
  output logic cke_o,
  output logic fwd_ok_o
);
  logic want, cke_q, awake_q;

  assign want  = !pd_auto_i || demand_i || busy_i;
  assign cke_o = early_i ? want : cke_q;
  // one full cycle of CKE high before anything is forwarded
  assign fwd_ok_o = cke_o && awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q   <= 1'b1;
      awake_q <= 1'b1;
    end else begin
      cke_q   <= want;
      awake_q <= cke_o;
    end
  end

  p_cke_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_auto_i |=> cke_q);
  p_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_auto_i && !demand_i && !busy_i |=> early_i || !cke_o);
  p_busy_awake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> cke_q);
endmodule

// File: rtl/sdram_refresh_cke_mgr.sv
module sdram_refresh_cke_mgr
  import rcm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PEND_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                period_we_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                rcnt_we_i,
  input  logic [RCNT_W-1:0]   rcnt_i,
  input  logic                pd_auto_i,
  input  logic                cke_early_i,
  input  logic [NUM_CH-1:0]   chan_en_i,
  output logic                ref_req_o,
  input  logic                ref_ack_i,
  input  logic                op_req_i,
  output logic                op_gnt_o,
  input  logic                op_busy_i,
  output logic                cke_o,
  output logic [RCNT_W-1:0]   rcnt_o
);
  logic owed, fwd_ok, take;

  assign take      = ref_req_o && ref_ack_i;
  assign ref_req_o = owed && fwd_ok;
  assign op_gnt_o  = op_req_i && fwd_ok;

  rcm_period_timer #(
    .PW(PERIOD_W), .PEND_W(PEND_W), .RST_PERIOD(PERIOD_RST)
  ) i_timer (
    .clk_i, .rst_ni,
    .period_we_i, .period_i,
    .run_i (|chan_en_i),
    .take_i(take),
    .owed_o(owed)
  );

  rcm_init_counter #(.CW(RCNT_W)) i_rcnt (
    .clk_i, .rst_ni,
    .load_i(rcnt_we_i),
    .val_i (rcnt_i),
    .done_i(take),
    .cnt_o (rcnt_o)
  );

  rcm_cke_ctrl i_cke (
    .clk_i, .rst_ni,
    .pd_auto_i,
    .early_i (cke_early_i),
    .demand_i(owed || op_req_i),
    .busy_i  (op_busy_i),
    .cke_o,
    .fwd_ok_o(fwd_ok)
  );

  p_fwd_after_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o || op_gnt_o |-> cke_o && $past(cke_o));
  p_req_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !ref_ack_i && !op_busy_i |=> owed);
endmodule

// File: tb/test_sdram_refresh_cke_mgr.sv
module test_sdram_refresh_cke_mgr;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 5;
  localparam int VEC_P   [NV] = '{5, 17, 64, 1, 0};
  localparam int VEC_EXP [NV] = '{5, 17, 64, 1, 1};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic period_we = 0, rcnt_we = 0, pd_auto = 0, early = 0;
  logic ref_ack = 0, op_req = 0, op_busy = 0;
  logic [11:0] period = '0;
  logic [4:0] rcnt_in = '0;
  logic [3:0] chan_en = '0;
  logic ref_req, op_gnt, cke;
  logic [4:0] rcnt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_cke_mgr i_sdram_refresh_cke_mgr (
    .clk_i(clk), .rst_ni(rst_ni),
    .period_we_i(period_we), .period_i(period),
    .rcnt_we_i(rcnt_we), .rcnt_i(rcnt_in),
    .pd_auto_i(pd_auto), .cke_early_i(early),
    .chan_en_i(chan_en),
    .ref_req_o(ref_req), .ref_ack_i(ref_ack),
    .op_req_i(op_req), .op_gnt_o(op_gnt), .op_busy_i(op_busy),
    .cke_o(cke), .rcnt_o(rcnt)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!ref_req && n < 4000) begin step(); n++; end
  endtask

  task automatic ack_once();
    ref_ack = 1; step(); ref_ack = 0;
  endtask

  task automatic drain();
    chan_en = '0;
    for (int k = 0; k < 8 && ref_req; k++) ack_once();
  endtask

  task automatic load_period(int p, logic [3:0] ch);
    period = 12'(p); period_we = 1; chan_en = ch; step(); period_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cke", cke, 1);
    chk("R1 req", ref_req, 0);
    chk("R1 gnt", op_gnt, 0);
    chk("R1 rcnt", rcnt, 0);
    chan_en = 4'b0100;
    wait_req(n);
    chk("R1 default interval", n, 780);
    ack_once();
    chk("R4 req cleared by handshake", ref_req, 0);

    // R2 interval table
    for (int v = 0; v < NV; v++) begin
      drain();
      load_period(VEC_P[v], 4'b0001);
      wait_req(n);
      chk("R2 first latency", n, VEC_EXP[v]);
      ref_ack = 1; step(); ref_ack = 0; n = 1;
      while (!ref_req && n < 4000) begin step(); n++; end
      chk("R2 interval", n, VEC_EXP[v]);
    end

    // R3 no refresh with channels off
    drain();
    load_period(4, 4'b0000);
    n = 0;
    for (int k = 0; k < 20; k++) begin step(); if (ref_req) n++; end
    chk("R3 no request while disabled", n, 0);

    // R4 backlog of two
    load_period(3, 4'b1000);
    repeat (6) step();
    chan_en = '0;
    chk("R4 owed held without ack", ref_req, 1);
    ref_ack = 1; step();
    chk("R4 second owed kept", ref_req, 1);
    step(); ref_ack = 0;
    chk("R4 backlog drained", ref_req, 0);

    // R5 init counter
    rcnt_in = 5'd3; rcnt_we = 1; step(); rcnt_we = 0;
    chk("R5 load", rcnt, 3);
    load_period(2, 4'b0010);
    for (int k = 0; k < 4; k++) begin
      wait_req(n); ack_once();
      chk("R5 countdown", rcnt, (k < 3) ? 2 - k : 0);
    end
    drain();
    rcnt_in = 5'd2; rcnt_we = 1; step(); rcnt_we = 0;
    chk("R5 reload after zero", rcnt, 2);

    // R6 power-down off
    op_req = 1; #1;
    chk("R6 gnt passthrough", op_gnt, 1);
    chk("R6 cke high", cke, 1);
    step(); op_req = 0;

    // R7 / R8 normal timing
    pd_auto = 1; step();
    chk("R7 cke low when idle", cke, 0);
    op_req = 1; #1;
    chk("R7 cke not yet up", cke, 0);
    step();
    chk("R7 cke rises", cke, 1);
    chk("R8 no gnt in wake cycle", op_gnt, 0);
    step();
    chk("R8 gnt after wake", op_gnt, 1);
    op_req = 0; op_busy = 1; step(); step();
    chk("R7 cke high while busy", cke, 1);
    op_busy = 0; #1;
    chk("R7 cke still high", cke, 1);
    step();
    chk("R7 cke falls", cke, 0);
    load_period(4, 4'b0001);
    wait_req(n);
    chk("R8 refresh latency with wake", n, 6);
    chk("R8 cke high with req", cke, 1);
    ref_ack = 1; op_busy = 1; step(); ref_ack = 0; chan_en = '0;
    step(); op_busy = 0; step();
    chk("R7 cke low after refresh", cke, 0);

    // R9 early timing
    early = 1; step();
    chk("R9 cke low idle", cke, 0);
    op_req = 1; #1;
    chk("R9 cke rises same cycle", cke, 1);
    chk("R9 no gnt yet", op_gnt, 0);
    step();
    chk("R9 gnt one cycle earlier", op_gnt, 1);
    op_req = 0; op_busy = 1; step();
    op_busy = 0; #1;
    chk("R9 cke falls same cycle", cke, 0);
    step();
    load_period(4, 4'b0001);
    wait_req(n);
    chk("R9 refresh latency early", n, 5);
    ref_ack = 1; op_busy = 1; step(); ref_ack = 0; chan_en = '0;
    op_busy = 0; step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule